// File: doc/BRIEF.md
# Single-Shot Sample Capture Buffer

This block is a one-pass capture memory for an 8-bit sample stream. Samples are written on the sample clock while the write enable is high. The stored samples can be read back only after the buffer holds the full selected depth. Readout is oldest sample first, and each sample can be read once. The depth select chooses 256, 512 or 1024 bytes, and the block samples that select only while reset is held.

Once the buffer is full, further writes take one of two paths chosen by a stop-on-full input. With the input low, writing continues and overwrites the oldest byte, so the buffer keeps the most recent window of samples. With the input high, writing stops at the full point. Reads are paced by a clock-enable strobe in the same clock domain. After the first byte has been read, the buffer ignores all writes until the next reset. An empty flag and a full flag report the fill state, and both update on the clock edge that changes the stored count.

Top module: `capbuf_top`

## Requirements
- R1: The depth select is sampled only while `srst` is high. The encoding is 2'b00 = 256 bytes, 2'b01 = 512 bytes, and 2'b10 or 2'b11 = 1024 bytes. Changes to `depth_sel` outside reset have no effect.
- R2: Bytes are returned in the order they were stored, oldest first.
- R3: No byte is delivered before the stored count first reaches the selected depth. Until then `rd_valid` stays low, whatever `ren` and `rd_ce` do.
- R4: `empty_flag` is high after reset. It is low from the edge that stores the first byte. It returns high on the edge that takes the last stored byte.
- R5: `full_flag` rises on the edge that stores the byte bringing the count to the selected depth. It falls on the edge of the first read.
- R6: While full, with `stop_on_full` low, an accepted write overwrites the oldest byte. The later readout then gives the most recent depth-many bytes, oldest first.
- R7: While full, with `stop_on_full` high, writes are ignored and the stored contents stay unchanged.
- R8: Once any byte has been read, writes are ignored until reset. A byte that has been read is never delivered again, and once empty the buffer delivers nothing more.
- R9: When a write is accepted in the same cycle as a read request, the write wins and no byte is delivered in that cycle.
- R10: A read is taken on an edge where `ren` and `rd_ce` are both high, the buffer is readable and the buffer is not empty. After that edge, `rd_valid` is high for exactly one cycle with the byte on `rd_data`. In every other cycle `rd_data` is 0.
- R11: Reset clears both pointers and the stored count in one cycle. After reset, `empty_flag` is 1 and `full_flag`, `rd_valid` and `rd_data` are 0. The first byte written after reset is the first byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| srst | input | 1 | Synchronous reset, active high |
| depth_sel | input | 2 | Depth select, sampled while in reset |
| wen | input | 1 | Write enable |
| wr_data | input | 8 | Sample byte to store |
| ren | input | 1 | Read enable |
| rd_ce | input | 1 | Read pacing strobe |
| stop_on_full | input | 1 | 1 = stop writing at full, 0 = overwrite oldest |
| rd_data | output | 8 | Delivered byte, 0 when not valid |
| rd_valid | output | 1 | One-cycle strobe per delivered byte |
| empty_flag | output | 1 | Buffer holds no bytes |
| full_flag | output | 1 | Buffer holds the selected depth |

## Verification
On every cycle, the assertions check several invariants. The stored count never exceeds the latched depth. The two flags are never high together. A delivered byte is always preceded by a read request and never appears before the buffer became readable. The write pointer stays still while full in stop mode. The count never grows after a read. The latched depth never changes outside reset. The bench scenarios are needed to show the data itself: readout order, which window survives an overwrite, and the exact edges on which the flags move. They are also needed for the per-byte pacing under the strobe and for the refusal of writes and re-reads after a partial readout.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;

    localparam int unsigned CB_SEL_W = 2;

    // Depth in bytes for a select code: minimum depth doubled per step, capped.
    function automatic int unsigned cb_depth_words(
        input logic [CB_SEL_W-1:0] sel,
        input int unsigned         min_d,
        input int unsigned         max_d
    );
        int unsigned d;
        d = min_d << sel;
        return (d > max_d) ? max_d : d;
    endfunction

endpackage

// File: rtl/capbuf_store.sv
module capbuf_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned AW     = 10
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned WORDS = 1 << AW;

    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_d = re ? mem[raddr] : '0;
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/capbuf_ctrl.sv
module capbuf_ctrl
    import capbuf_pkg::*;
#(
    parameter int unsigned MIN_DEPTH = 256,
    parameter int unsigned MAX_DEPTH = 1024,
    parameter int unsigned AW        = $clog2(MAX_DEPTH),
    parameter int unsigned CW        = AW + 1
) (
    input  logic                clk,
    input  logic                srst,
    input  logic [CB_SEL_W-1:0] depth_sel,
    input  logic                wen,
    input  logic                ren,
    input  logic                rd_ce,
    input  logic                stop_on_full,
    output logic                mem_we,
    output logic [AW-1:0]       mem_waddr,
    output logic                mem_re,
    output logic [AW-1:0]       mem_raddr,
    output logic                rd_valid,
    output logic                empty_flag,
    output logic                full_flag
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic [CW-1:0] depth;
        logic          readable;
        logic          locked;
        logic          rd_valid;
        logic          ef;
        logic          ff;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        at_full;
    logic        wr_ok;
    logic        rd_ok;
    logic [CW-1:0] sel_depth;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p,
                                                input logic [CW-1:0] d);
        if (({1'b0, p} + CW'(1)) == d) begin
            return '0;
        end
        return p + AW'(1);
    endfunction

    always_comb begin
        sel_depth = CW'(cb_depth_words(depth_sel, MIN_DEPTH, MAX_DEPTH));
        at_full   = (st_q.count == st_q.depth);
        wr_ok     = wen && !st_q.locked && !(at_full && stop_on_full);
        rd_ok     = ren && rd_ce && st_q.readable && (st_q.count != '0) && !wr_ok;

        st_d = st_q;
        if (wr_ok) begin
            st_d.wr_ptr = ptr_next(st_q.wr_ptr, st_q.depth);
            if (at_full) begin
                // overwrite: the oldest byte is gone, so read start moves on
                st_d.rd_ptr = ptr_next(st_q.rd_ptr, st_q.depth);
            end else begin
                st_d.count = st_q.count + CW'(1);
            end
        end
        if (rd_ok) begin
            st_d.rd_ptr = ptr_next(st_q.rd_ptr, st_q.depth);
            st_d.count  = st_q.count - CW'(1);
            st_d.locked = 1'b1;
        end
        st_d.readable = st_q.readable || (st_d.count == st_q.depth);
        st_d.rd_valid = rd_ok;
        st_d.ef       = (st_d.count == '0);
        st_d.ff       = (st_d.count == st_q.depth);

        if (srst) begin
            st_d          = '0;
            st_d.depth    = sel_depth;
            st_d.ef       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mem_we     = wr_ok && !srst;
    assign mem_waddr  = st_q.wr_ptr;
    assign mem_re     = rd_ok && !srst;
    assign mem_raddr  = st_q.rd_ptr;
    assign rd_valid   = st_q.rd_valid;
    assign empty_flag = st_q.ef;
    assign full_flag  = st_q.ff;

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (srst)
        st_q.count <= st_q.depth);

    // R4
    flags_excl_chk: assert property (@(posedge clk) disable iff (srst)
        !(st_q.ef && st_q.ff));

    // R10
    valid_after_req_chk: assert property (@(posedge clk) disable iff (srst)
        st_q.rd_valid |-> $past(ren && rd_ce));

    // R3
    no_early_read_chk: assert property (@(posedge clk) disable iff (srst)
        st_q.rd_valid |-> st_q.readable);

    // R7
    stop_holds_ptr_chk: assert property (@(posedge clk) disable iff (srst)
        (st_q.ff && stop_on_full) |=> $stable(st_q.wr_ptr));

    // R8
    locked_no_grow_chk: assert property (@(posedge clk) disable iff (srst)
        st_q.locked |=> (st_q.count <= $past(st_q.count)));

    // R1
    depth_held_chk: assert property (@(posedge clk) disable iff (srst)
        1'b1 |=> $stable(st_q.depth));

endmodule

// File: rtl/capbuf_top.sv
module capbuf_top
    import capbuf_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned MIN_DEPTH = 256,
    parameter int unsigned MAX_DEPTH = 1024
) (
    input  logic              clk,
    input  logic              srst,
    input  logic [1:0]        depth_sel,
    input  logic              wen,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ren,
    input  logic              rd_ce,
    input  logic              stop_on_full,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty_flag,
    output logic              full_flag
);
    localparam int unsigned AW = $clog2(MAX_DEPTH);
    localparam int unsigned CW = AW + 1;

    logic          mem_we, mem_re;
    logic [AW-1:0] mem_waddr, mem_raddr;

    capbuf_ctrl #(
        .MIN_DEPTH (MIN_DEPTH),
        .MAX_DEPTH (MAX_DEPTH),
        .AW        (AW),
        .CW        (CW)
    ) u_ctrl (
        .clk          (clk),
        .srst         (srst),
        .depth_sel    (depth_sel),
        .wen          (wen),
        .ren          (ren),
        .rd_ce        (rd_ce),
        .stop_on_full (stop_on_full),
        .mem_we       (mem_we),
        .mem_waddr    (mem_waddr),
        .mem_re       (mem_re),
        .mem_raddr    (mem_raddr),
        .rd_valid     (rd_valid),
        .empty_flag   (empty_flag),
        .full_flag    (full_flag)
    );

    capbuf_store #(
        .DATA_W (DATA_W),
        .AW     (AW)
    ) u_store (
        .clk   (clk),
        .srst  (srst),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (rd_data)
    );

endmodule

// File: tb/capbuf_top_test.sv
`timescale 1ns/1ps
module capbuf_top_test;

    logic       clk = 1'b0;
    logic       srst = 1'b1;
    logic [1:0] depth_sel = 2'b00;
    logic       wen = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ren = 1'b0;
    logic       rd_ce = 1'b0;
    logic       stop_on_full = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid, empty_flag, full_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    capbuf_top uut (
        .clk(clk), .srst(srst), .depth_sel(depth_sel), .wen(wen),
        .wr_data(wr_data), .ren(ren), .rd_ce(rd_ce), .stop_on_full(stop_on_full),
        .rd_data(rd_data), .rd_valid(rd_valid), .empty_flag(empty_flag),
        .full_flag(full_flag)
    );

    // {sel[17:16], stop[15], extra[14:11], depth[10:0]}
    localparam logic [17:0] VEC [6] = '{
        {2'b00, 1'b0, 4'd0, 11'd256},
        {2'b01, 1'b0, 4'd3, 11'd512},
        {2'b10, 1'b1, 4'd5, 11'd1024},
        {2'b11, 1'b0, 4'd2, 11'd1024},
        {2'b00, 1'b1, 4'd4, 11'd256},
        {2'b01, 1'b0, 4'd1, 11'd512}
    };

    function automatic logic [7:0] pat(input int k, input int seed);
        return 8'((k * 37) + (seed * 11) + 5);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] sel);
        srst = 1'b1; depth_sel = sel; wen = 1'b0; ren = 1'b0; rd_ce = 1'b0;
        step(); step();
        srst = 1'b0;
        depth_sel = ~sel;   // R1: must not matter after reset
    endtask

    task automatic fill(input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            wr_data = pat(k, seed); wen = 1'b1;
            step();
        end
        wen = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int d, ex, start, reads;
        logic st;

        // R11: write a few bytes, then reset and check the idle state
        do_reset(2'b00);
        fill(5, 1);
        srst = 1'b1; wen = 1'b1; ren = 1'b1; rd_ce = 1'b1;
        step();
        wen = 1'b0; ren = 1'b0; rd_ce = 1'b0; srst = 1'b0;
        chk(empty_flag == 1'b1, "R11 ef after reset", empty_flag, 1);
        chk(full_flag == 1'b0, "R11 ff after reset", full_flag, 0);
        chk(rd_valid == 1'b0, "R11 valid after reset", rd_valid, 0);
        chk(rd_data == 8'h00, "R11 data after reset", rd_data, 0);

        // Vector table
        for (int v = 0; v < 6; v++) begin
            d  = int'(VEC[v][10:0]);
            ex = int'(VEC[v][14:11]);
            st = VEC[v][15];
            do_reset(VEC[v][17:16]);
            stop_on_full = st;
            for (int k = 0; k < d + ex; k++) begin
                wr_data = pat(k, v); wen = 1'b1;
                if (k >= d && !st) begin ren = 1'b1; rd_ce = 1'b1; end
                step();
                wen = 1'b0; ren = 1'b0; rd_ce = 1'b0;
                if (k == 0) chk(empty_flag == 1'b0, "R4 ef low after first write", empty_flag, 0);
                if (k >= d && !st) chk(rd_valid == 1'b0, "R9 write wins over read", rd_valid, 0);
                if (k == d - 2) begin
                    chk(full_flag == 1'b0, "R5 ff low one short", full_flag, 0);
                    ren = 1'b1; rd_ce = 1'b1;
                    step();
                    ren = 1'b0; rd_ce = 1'b0;
                    chk(rd_valid == 1'b0, "R3 read blocked before full", rd_valid, 0);
                end
                if (k == d - 1) chk(full_flag == 1'b1, "R5 ff at depth (R1 depth)", full_flag, 1);
            end
            start = st ? 0 : ex;
            for (int j = 0; j < d; j++) begin
                ren = 1'b1; rd_ce = 1'b1;
                step();
                chk(rd_valid == 1'b1, "R10 valid per read", rd_valid, 1);
                chk(rd_data == pat(start + j, v), st ? "R7 R2 order" : "R6 R2 order",
                    rd_data, pat(start + j, v));
                if (j == 0) chk(full_flag == 1'b0, "R5 ff clears on read", full_flag, 0);
                if (j == d - 1) chk(empty_flag == 1'b1, "R4 ef after last read", empty_flag, 1);
                else if (j == 0) chk(empty_flag == 1'b0, "R4 ef low mid read", empty_flag, 0);
                rd_ce = 1'b0;
                step();
                chk(rd_valid == 1'b0 && rd_data == 8'h00, "R10 idle between strobes", rd_data, 0);
            end
            ren = 1'b1; rd_ce = 1'b1;
            step();
            ren = 1'b0; rd_ce = 1'b0;
            chk(rd_valid == 1'b0, "R8 no re-read after empty", rd_valid, 0);
        end

        // R8: partial read, then writes are ignored
        do_reset(2'b00);
        stop_on_full = 1'b0;
        fill(256, 9);
        for (int j = 0; j < 10; j++) begin
            ren = 1'b1; rd_ce = 1'b1;
            step();
            chk(rd_data == pat(j, 9), "R8 partial read data", rd_data, pat(j, 9));
        end
        ren = 1'b0; rd_ce = 1'b0;
        for (int j = 0; j < 5; j++) begin
            wen = 1'b1; wr_data = 8'hAA;
            step();
        end
        wen = 1'b0;
        chk(full_flag == 1'b0, "R8 ff stays low after ignored writes", full_flag, 0);
        // R10: rd_ce low holds off reads
        ren = 1'b1; rd_ce = 1'b0;
        step();
        chk(rd_valid == 1'b0, "R10 no read without strobe", rd_valid, 0);
        reads = 0;
        for (int j = 0; j < 300 && !empty_flag; j++) begin
            rd_ce = 1'b1;
            step();
            if (rd_valid) begin
                chk(rd_data == pat(10 + reads, 9), "R8 remaining data", rd_data, pat(10 + reads, 9));
                reads++;
            end
        end
        ren = 1'b0; rd_ce = 1'b0;
        chk(reads == 246, "R8 writes after partial read ignored", reads, 246);

        // R11: first byte after reset is first read
        do_reset(2'b00);
        fill(256, 4);
        ren = 1'b1; rd_ce = 1'b1;
        step();
        ren = 1'b0; rd_ce = 1'b0;
        chk(rd_data == pat(0, 4), "R11 pointers cleared", rd_data, pat(0, 4));

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule